// File: doc/BRIEF.md
# Threshold-Crossing Frequency Halver

This block watches a stream of signed samples and emits a one-bit square wave at half the frequency of the sampled signal. Each accepted sample is first scaled by an unsigned integer gain, which makes slow edges steeper. The scaled value is clamped to the sample range. It is then compared against a signed threshold that software or a neighbouring block supplies. Every time the scaled signal moves from below the threshold to at-or-above it, the output bit flips. Two upward crossings therefore make one full output period.

For every accepted input sample there is exactly one output bit, carried on its own valid strobe one clock later. The output rate thus equals the input rate, and the square wave stays time-aligned with the input. With a perfectly sharp input edge, the output changes on the output sample that belongs to the crossing input sample, which is one clock after that sample arrives.

Top module: `thresh_halver`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_bit` is 0 and `out_valid` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, so that one output bit is produced for each accepted sample.
- R3: A rising crossing is an accepted sample whose scaled value is greater than or equal to `threshold` while the previously accepted scaled value was strictly below it. Equality counts as reaching the threshold. The resulting flip appears on `out_bit` with the `out_valid` strobe of that same sample, one clock after it is accepted.
- R4: The first rising crossing after reset drives `out_bit` to 1, the next one drives it to 0, and this alternation continues without end.
- R5: Falling crossings, and samples that stay on the same side of the threshold, leave `out_bit` unchanged.
- R6: The first accepted sample after reset only loads the history and never flips `out_bit`, even when it is at or above the threshold.
- R7: `threshold` is a two's-complement value of the sample width and may be any value. A value of 0 makes the detector respond to negative-to-non-negative transitions.
- R8: The compared value is `in_sample` times `gain`, with `gain` read as an unsigned integer. A gain of 1 passes the sample through unchanged, and a gain of 0 makes every scaled value 0.
- R9: The scaled value saturates to the signed sample range, from -2^(SAMPLE_W-1) to 2^(SAMPLE_W-1)-1. A large positive product therefore never wraps to a negative value, and a large negative product never wraps to a positive value.
- R10: Cycles without `in_valid` change neither `out_bit` nor the stored history, whatever `in_sample` holds during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Marks `in_sample` as an accepted sample this cycle |
| in_sample | input | SAMPLE_W | Signed input sample |
| threshold | input | SAMPLE_W | Signed comparison level |
| gain | input | GAIN_W | Unsigned integer scale applied before the comparison |
| out_valid | output | 1 | Strobe for `out_bit`, one clock after `in_valid` |
| out_bit | output | 1 | Half-frequency square wave |

## Verification
The main function is driven with a zero-threshold bipolar sequence. That sequence separates upward crossings from downward crossings, from steady runs and from exact hits on the threshold. A non-zero threshold shows that the comparison level is applied and that the equality case counts. A gain that lifts a sub-threshold sample onto the level shows that scaling happens before the comparison. Gain 0 removes every crossing. Near-full-scale products with the largest gain tell saturation apart from wrap-around, because a wrapped product would land on the wrong side of zero. Idle cycles with wild sample values, and a reset in mid-stream, show that the history is only touched by accepted samples and that the first sample after reset is only loaded.

// File: rtl/halver_pkg.sv
package halver_pkg;

  // Classification of one accepted sample against the previous one.
  typedef enum logic [1:0] {
    LVL_PRIME = 2'd0,  // no history yet: only load
    LVL_HOLD  = 2'd1,  // same side as before
    LVL_RISE  = 2'd2,  // below -> at/above threshold
    LVL_FALL  = 2'd3   // at/above -> below threshold
  } level_evt_e;

endpackage

// File: rtl/halver_gain.sv
module halver_gain #(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 4
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [GAIN_W-1:0]   gain,
  output logic signed [SAMPLE_W-1:0] scaled
);

  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MIN_V = -PROD_W'(2 ** (SAMPLE_W - 1));

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(sample) * $signed({1'b0, gain});
    if (prod > MAX_V) begin
      scaled = MAX_V[SAMPLE_W-1:0];
    end else if (prod < MIN_V) begin
      scaled = MIN_V[SAMPLE_W-1:0];
    end else begin
      scaled = prod[SAMPLE_W-1:0];
    end
  end

endmodule

// File: rtl/halver_cross.sv
module halver_cross
  import halver_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] scaled,
  input  logic signed [SAMPLE_W-1:0] threshold,
  output level_evt_e                 evt,
  output logic                       primed
);

  logic signed [SAMPLE_W-1:0] hist_q, hist_d;
  logic                       primed_d;
  logic                       now_hi, was_hi;

  always_comb begin
    now_hi = (scaled >= threshold);
    was_hi = (hist_q >= threshold);
    if (!primed) begin
      evt = LVL_PRIME;
    end else if (now_hi && !was_hi) begin
      evt = LVL_RISE;
    end else if (!now_hi && was_hi) begin
      evt = LVL_FALL;
    end else begin
      evt = LVL_HOLD;
    end
    hist_d   = take ? scaled : hist_q;
    primed_d = primed | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      primed <= 1'b0;
    end else begin
      hist_q <= hist_d;
      primed <= primed_d;
    end
  end

endmodule

// File: rtl/halver_toggle.sv
module halver_toggle
  import halver_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  level_evt_e evt,
  output logic       out_valid,
  output logic       out_bit
);

  logic bit_d;

  always_comb begin
    bit_d = out_bit;
    if (take && (evt == LVL_RISE)) begin
      bit_d = ~out_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_bit   <= bit_d;
      out_valid <= take;
    end
  end

endmodule

// File: rtl/thresh_halver.sv
module thresh_halver
  import halver_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic signed [SAMPLE_W-1:0] threshold,
  input  logic        [GAIN_W-1:0]   gain,
  output logic                       out_valid,
  output logic                       out_bit
);

  logic signed [SAMPLE_W-1:0] scaled;
  level_evt_e                 evt;
  logic                       primed;

  halver_gain #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_gain (
    .sample (in_sample),
    .gain   (gain),
    .scaled (scaled)
  );

  halver_cross #(.SAMPLE_W(SAMPLE_W)) u_cross (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid),
    .scaled    (scaled),
    .threshold (threshold),
    .evt       (evt),
    .primed    (primed)
  );

  halver_toggle u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid),
    .evt       (evt),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

endmodule

// File: rtl/halver_chk.sv
module halver_chk #(
  parameter int SAMPLE_W = 12,
  parameter int GAIN_W   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_sample,
  input logic signed [SAMPLE_W-1:0] threshold,
  input logic        [GAIN_W-1:0]   gain,
  input logic signed [SAMPLE_W-1:0] scaled,
  input logic                       primed,
  input logic                       out_valid,
  input logic                       out_bit
);

  // R1: outputs held at zero while reset is low
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (out_bit == 1'b0 && out_valid == 1'b0);
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: a flip needs an accepted sample at or above the threshold
  assert_flip_needs_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_bit) |-> ($past(in_valid) && ($past(scaled) >= $past(threshold))));

  assert_prime_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed) |=> $stable(out_bit));

  assert_sat_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample > 0 && gain != '0) |-> (scaled > 0));

  assert_sat_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample < 0 && gain != '0) |-> (scaled < 0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_bit));

endmodule

bind thresh_halver halver_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .threshold (threshold),
  .gain      (gain),
  .scaled    (scaled),
  .primed    (primed),
  .out_valid (out_valid),
  .out_bit   (out_bit)
);

// File: tb/thresh_halver_test.sv
module thresh_halver_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int GW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic signed [SW-1:0] threshold = '0;
  logic        [GW-1:0] gain = 4'd1;
  logic                 out_valid;
  logic                 out_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  thresh_halver #(.SAMPLE_W(SW), .GAIN_W(GW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .threshold (threshold),
    .gain      (gain),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: present one sample, look at its output bit one clock later.
  task automatic send(input int s, input logic exp_bit, input string req);
    in_sample = SW'(s);
    in_valid  = 1'b1;
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), 1);
    check(req, int'(out_bit), int'(exp_bit));
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 out_bit in reset", int'(out_bit), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_bit after release", int'(out_bit), 0);
  endtask

  task automatic t_basic();
    threshold = '0;
    gain = 4'd1;
    send(100, 1'b0, "R6 first sample only primes");
    send(-5, 1'b0, "R5 falling leaves bit");
    send(5, 1'b1, "R3 R4 first rise sets 1");
    send(200, 1'b1, "R5 steady high");
    send(-1, 1'b1, "R5 falling leaves bit");
    send(-7, 1'b1, "R5 steady low");
    send(0, 1'b0, "R3 R4 equality rise clears to 0");
    send(-3, 1'b0, "R5 falling");
    send(9, 1'b1, "R4 alternation continues");
  endtask

  task automatic t_idle();
    // history now 9 (at/above 0); idle junk must not replace it
    @(negedge clk);
    check("R2 idle out_valid", int'(out_valid), 0);
    in_sample = -SW'(900);
    @(negedge clk);
    check("R10 idle bit held", int'(out_bit), 1);
    in_sample = SW'(0);
    send(50, 1'b1, "R10 idle sample not in history");
  endtask

  task automatic t_threshold();
    threshold = SW'(300);
    send(299, 1'b1, "R7 below raised level");
    send(300, 1'b0, "R7 equality at raised level");
    send(250, 1'b0, "R7 fall below level");
    send(400, 1'b1, "R7 rise over level");
    threshold = -SW'(100);
    send(-150, 1'b1, "R7 below negative level");
    send(-100, 1'b0, "R7 rise at negative level");
  endtask

  task automatic t_gain();
    threshold = SW'(400);
    gain = 4'd4;
    send(50, 1'b0, "R8 scaled 200 below 400");
    send(99, 1'b0, "R8 scaled 396 below 400");
    send(100, 1'b1, "R8 scaled 400 reaches level");
    gain = 4'd0;
    threshold = '0;
    send(-500, 1'b1, "R8 gain zero no fall");
    send(-700, 1'b1, "R8 gain zero steady");
    threshold = SW'(1);
    send(500, 1'b1, "R8 gain zero below 1");
    send(-500, 1'b1, "R8 gain zero still below 1");
  endtask

  task automatic t_sat();
    gain = 4'd15;
    threshold = '0;
    send(-10, 1'b1, "R9 scaled -150");
    send(1000, 1'b0, "R9 positive clamp rises");
    send(-1000, 1'b0, "R9 negative clamp falls");
    send(1, 1'b1, "R9 rise after negative clamp");
    threshold = SW'(2047);
    send(-2048, 1'b1, "R9 min clamp");
    send(2047, 1'b0, "R9 max clamp meets top level");
  endtask

  task automatic t_midreset();
    do_reset();
    gain = 4'd1;
    threshold = '0;
    send(300, 1'b0, "R6 first sample after reset primes");
    send(-300, 1'b0, "R5 fall after reset");
    send(300, 1'b1, "R4 first rise after reset sets 1");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 out_bit in reset", int'(out_bit), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_idle();
    t_threshold();
    t_gain();
    t_sat();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule